// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Flags and Partial Reset

This block is a first-in first-out queue of 36-bit words. A producer writes on one clock and a consumer reads on another. The two clocks may be unrelated or may be the same clock. Storage is an inferred dual-port memory. Its depth is a parameter and must be a power of two: 256, 512 or 1024 words. The write side drives `full` and `almost_full`. The read side drives `empty` and `almost_empty`. The two almost flags use offsets that can be programmed.

A full reset (`rst_n` low) returns both pointers to the first word. While `rst_n` is low, the block samples `cfg_mode` on each write clock edge. This chooses how the two offsets are obtained: a fixed default, a load over the parallel data bus, or a load one bit at a time. A partial reset (`prst_n` low) empties the queue and keeps everything else. Both offsets stay as they are, and so does the loading state reached. Each pointer crosses to the other clock domain as Gray code through a two-stage synchronizer. As a result, each flag is exact for changes made by its own port. A flag may stay asserted a few cycles of its own clock longer than needed after the other port has moved.

The offset controller is a small state machine in the write domain. When a full reset ends, it enters one of three states:
- `ST_RUN` for the default modes.
- `ST_PAR_EMPTY` for parallel loading. It moves to `ST_PAR_FULL` after one write strobe, then to `ST_RUN` after the next.
- `ST_SER_EMPTY` for serial loading. It moves to `ST_SER_FULL` after AW strobes, then to `ST_RUN` after AW more.

`ST_RUN` is left only through a full reset. Normal writes are accepted only in `ST_RUN`.

Top module: `xclk_fifo`

## Requirements
- R1: A word is written on a rising `wclk` edge when `wr_en` is 1, `full` is 0 and offset loading is complete. A word is read on a rising `rclk` edge when `rd_en` is 1 and `empty` is 0. `rd_data` is registered and shows the word read, in write order, after that read edge.
- R2: `full` is 1 whenever DEPTH words are stored. A write attempted while `full` is 1 is ignored, and no word is added.
- R3: `empty` is 1 whenever no word is stored. A read attempted while `empty` is 1 is ignored, and `rd_data` keeps its value.
- R4: Once the pointers have settled, `almost_empty` is 1 exactly when the stored word count is at or below the empty offset.
- R5: Once the pointers have settled, `almost_full` is 1 exactly when the free space (DEPTH minus the count) is at or below the full offset.
- R6: After a full reset the queue is empty: `empty`=1, `full`=0, `almost_empty`=1, `almost_full`=0. A `cfg_mode` of 0, 1 or 2 sets both offsets to 8, 16 or 64. Any code above 4 acts as 0.
- R7: With `cfg_mode`=3, the first write strobe after a full reset loads the empty offset from `wr_data[AW-1:0]`. The second strobe loads the full offset the same way. Neither word is queued.
- R8: With `cfg_mode`=4, each `wclk` edge with `wr_en`=1 shifts `ser_bit` into an offset, least significant bit first. The first AW bits form the empty offset and the next AW bits form the full offset. Nothing is queued until all 2*AW bits have been shifted.
- R9: A partial reset empties the queue, so the first word read afterwards is the first word written afterwards. It leaves both offsets and the programming method unchanged.
- R10: Data order and flag rules hold both with one shared clock and with unrelated clocks. Each Gray pointer changes by at most one bit per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Full reset, active low; resets pointers and offset programming |
| prst_n | input | 1 | Partial reset, active low; resets pointers only |
| cfg_mode | input | 3 | Offset source sampled during full reset: 0/1/2 default 8/16/64, 3 parallel, 4 serial |
| wr_en | input | 1 | Write strobe (also the load strobe while offsets are loading) |
| wr_data | input | 36 | Write word; low AW bits carry an offset during parallel loading |
| ser_bit | input | 1 | Serial offset bit |
| full | output | 1 | Queue holds DEPTH words |
| almost_full | output | 1 | Free space at or below the full offset |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 36 | Last word read |
| empty | output | 1 | Queue holds no word |
| almost_empty | output | 1 | Stored count at or below the empty offset |

## Verification
The queue is filled and drained with one shared clock, and then with a 7 ns read clock against a 5 ns write clock. With the shared clock, each synchronizer delay lines up with the same edges every time. With unrelated clocks, the edges slip against each other and expose Gray-code or synchronizer faults. Bursts stop exactly on each offset, one word either side of it, and at completely full and completely empty. These stopping points show whether each comparison is "at or below" and whether the free-space arithmetic is off by one. The same thresholds are checked again after a partial reset. Words written while the queue is full or while offsets are loading, and reads made while it is empty, show that rejected strobes leave the contents untouched.

// File: rtl/xcf_pkg.sv
package xcf_pkg;

    typedef enum logic [2:0] {
        MODE_OFS8  = 3'd0,
        MODE_OFS16 = 3'd1,
        MODE_OFS64 = 3'd2,
        MODE_PAR   = 3'd3,
        MODE_SER   = 3'd4
    } ofs_mode_e;

    typedef enum logic [2:0] {
        ST_PAR_EMPTY,
        ST_PAR_FULL,
        ST_SER_EMPTY,
        ST_SER_FULL,
        ST_RUN
    } cfg_state_e;

endpackage

// File: rtl/xcf_sync.sv
module xcf_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/xcf_ofs_ctl.sv
module xcf_ofs_ctl
    import xcf_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic [2:0]    cfg_mode,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_low,
    input  logic          ser_bit,
    output logic [AW-1:0] ofs_e,
    output logic [AW-1:0] ofs_f,
    output logic          ready
);

    localparam int CW = $clog2(AW + 1);

    cfg_state_e     st, st_nx, st_start;
    logic [CW-1:0]  bcnt;
    logic           last_bit;

    assign last_bit = (bcnt == CW'(AW - 1));
    assign ready    = (st == ST_RUN);

    always_comb begin
        case (cfg_mode)
            MODE_PAR: st_start = ST_PAR_EMPTY;
            MODE_SER: st_start = ST_SER_EMPTY;
            default:  st_start = ST_RUN;
        endcase
    end

    // state register: full reset chooses the entry state
    always_ff @(posedge wclk) begin
        if (!rst_n) st <= st_start;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_PAR_EMPTY: if (wr_en) st_nx = ST_PAR_FULL;
            ST_PAR_FULL:  if (wr_en) st_nx = ST_RUN;
            ST_SER_EMPTY: if (wr_en && last_bit) st_nx = ST_SER_FULL;
            ST_SER_FULL:  if (wr_en && last_bit) st_nx = ST_RUN;
            ST_RUN:       st_nx = ST_RUN;
            default:      st_nx = ST_RUN;
        endcase
    end

    // offset registers: untouched by partial reset
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            bcnt <= '0;
            case (cfg_mode)
                MODE_OFS16: begin ofs_e <= AW'(16); ofs_f <= AW'(16); end
                MODE_OFS64: begin ofs_e <= AW'(64); ofs_f <= AW'(64); end
                default:    begin ofs_e <= AW'(8);  ofs_f <= AW'(8);  end
            endcase
        end else begin
            unique case (st)
                ST_PAR_EMPTY: if (wr_en) ofs_e <= wr_low;
                ST_PAR_FULL:  if (wr_en) ofs_f <= wr_low;
                ST_SER_EMPTY: if (wr_en) begin
                    ofs_e <= {ser_bit, ofs_e[AW-1:1]};
                    bcnt  <= last_bit ? '0 : bcnt + 1'b1;
                end
                ST_SER_FULL: if (wr_en) begin
                    ofs_f <= {ser_bit, ofs_f[AW-1:1]};
                    bcnt  <= last_bit ? '0 : bcnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R9
    ofs_hold_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        ready |=> ($stable(ofs_e) && $stable(ofs_f)));

    // R7
    par_load_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        (st == ST_PAR_EMPTY && wr_en) |=> (ofs_e == $past(wr_low)));

endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
    import xcf_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 36
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              prst_n,
    input  logic [2:0]        cfg_mode,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ser_bit,
    output logic              full,
    output logic              almost_full,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              almost_empty
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wbin, wgray, rbin, rgray, wg_s, rg_s;
    logic [PW-1:0]     wlevel, rlevel;
    logic [AW-1:0]     ofs_e, ofs_f;
    logic              clr_n, cfg_ready, wr_go, rd_go;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    assign clr_n = rst_n & prst_n;

    xcf_ofs_ctl #(.AW(AW)) u_ofs (
        .wclk     (wclk),
        .rst_n    (rst_n),
        .cfg_mode (cfg_mode),
        .wr_en    (wr_en),
        .wr_low   (wr_data[AW-1:0]),
        .ser_bit  (ser_bit),
        .ofs_e    (ofs_e),
        .ofs_f    (ofs_f),
        .ready    (cfg_ready)
    );

    xcf_sync #(.W(PW)) u_wptr_sync (.clk(rclk), .clr_n(clr_n), .d(wgray), .q(wg_s));
    xcf_sync #(.W(PW)) u_rptr_sync (.clk(wclk), .clr_n(clr_n), .d(rgray), .q(rg_s));

    // write domain
    assign wr_go       = wr_en && cfg_ready && !full;
    assign full        = (wgray == {~rg_s[PW-1:PW-2], rg_s[PW-3:0]});
    assign wlevel      = wbin - from_gray(rg_s);
    assign almost_full = (PW'(DEPTH) - wlevel) <= {1'b0, ofs_f};

    always_ff @(posedge wclk or negedge clr_n) begin
        if (!clr_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (wr_go) begin
            wbin  <= wbin + 1'b1;
            wgray <= to_gray(wbin + 1'b1);
        end
    end

    always_ff @(posedge wclk) begin
        if (wr_go) mem[wbin[AW-1:0]] <= wr_data;
    end

    // read domain
    assign rd_go        = rd_en && !empty;
    assign empty        = (rgray == wg_s);
    assign rlevel       = from_gray(wg_s) - rbin;
    assign almost_empty = rlevel <= {1'b0, ofs_e};

    always_ff @(posedge rclk or negedge clr_n) begin
        if (!clr_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (rd_go) begin
            rbin  <= rbin + 1'b1;
            rgray <= to_gray(rbin + 1'b1);
        end
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_go) rd_data <= mem[rbin[AW-1:0]];
    end

    // R2
    wr_full_hold_chk: assert property (@(posedge wclk) disable iff (!clr_n)
        (wr_en && full) |=> $stable(wbin));

    // R2
    wr_level_bound_chk: assert property (@(posedge wclk) disable iff (!clr_n)
        wlevel <= PW'(DEPTH));

    // R3
    rd_empty_hold_chk: assert property (@(posedge rclk) disable iff (!clr_n)
        (rd_en && empty) |=> ($stable(rbin) && $stable(rd_data)));

    // R10
    wgray_step_chk: assert property (@(posedge wclk) disable iff (!clr_n)
        1'b1 |=> $onehot0(wgray ^ $past(wgray)));

    // R10
    rgray_step_chk: assert property (@(posedge rclk) disable iff (!clr_n)
        1'b1 |=> $onehot0(rgray ^ $past(rgray)));

endmodule

// File: tb/xclk_fifo_tb.sv
`timescale 1ns/100ps
module xclk_fifo_tb_top;

    localparam int DEPTH = 256;
    localparam int AW    = 8;

    logic        wclk = 1'b0, rclk = 1'b0;
    logic        rst_n = 1'b0, prst_n = 1'b1;
    logic [2:0]  cfg_mode = 3'd0;
    logic        wr_en = 1'b0, rd_en = 1'b0, ser_bit = 1'b0;
    logic [35:0] wr_data = '0;
    logic [35:0] rd_data;
    logic        full, almost_full, empty, almost_empty;

    realtime rhalf = 2.5;
    always #2.5 wclk = ~wclk;
    always #(rhalf) rclk = ~rclk;

    xclk_fifo #(.DEPTH(DEPTH), .DATA_W(36)) dut_i (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .prst_n(prst_n),
        .cfg_mode(cfg_mode), .wr_en(wr_en), .wr_data(wr_data), .ser_bit(ser_bit),
        .full(full), .almost_full(almost_full), .rd_en(rd_en), .rd_data(rd_data),
        .empty(empty), .almost_empty(almost_empty)
    );

    int checks = 0, errors = 0;
    int exp_oe = 8, exp_of = 8;
    int wctr = 0;
    bit model_on = 1'b0, done = 1'b0;
    logic [35:0] q[$];
    logic [35:0] exp_rd, hold_rd;
    bit rd_pend = 1'b0, hold_pend = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // reference model: write side
    always @(posedge wclk) begin
        if (rst_n && prst_n && model_on && wr_en && !full) q.push_back(wr_data);
    end

    // reference model: read side
    always @(posedge rclk) begin
        if (rst_n && prst_n && rd_en) begin
            if (!empty) begin
                if (q.size() == 0) chk(1'b0, "R3", "read accepted with empty model", 0, 0);
                else begin exp_rd = q.pop_front(); rd_pend = 1'b1; end
            end else begin
                hold_rd = rd_data; hold_pend = 1'b1;
            end
        end
    end

    always @(negedge rclk) begin
        if (rd_pend) begin
            chk(rd_data == exp_rd, "R1", "read word", rd_data, exp_rd);
            rd_pend = 1'b0;
        end
        if (hold_pend) begin
            chk(rd_data == hold_rd, "R3", "rd_data after empty read", rd_data, hold_rd);
            hold_pend = 1'b0;
        end
        if (rst_n && prst_n && q.size() == 0)
            chk(empty == 1'b1, "R3", "empty with no stored word", empty, 1);
    end

    always @(negedge wclk) begin
        if (rst_n && prst_n && q.size() == DEPTH)
            chk(full == 1'b1, "R2", "full with DEPTH stored", full, 1);
    end

    task automatic full_reset(input int mode);
        @(negedge wclk);
        wr_en = 0; rd_en = 0; cfg_mode = 3'(mode); rst_n = 0; model_on = 0;
        q.delete();
        repeat (4) @(negedge wclk);
        rst_n = 1;
        repeat (2) @(negedge wclk);
    endtask

    task automatic part_reset();
        @(negedge wclk);
        wr_en = 0; rd_en = 0; prst_n = 0;
        q.delete();
        repeat (3) @(negedge wclk);
        prst_n = 1;
        repeat (2) @(negedge wclk);
    endtask

    task automatic push_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wclk);
            wctr++;
            wr_en = 1; wr_data = {4'h9, 32'(wctr) * 32'h9E37_79B1};
        end
        @(negedge wclk);
        wr_en = 0;
    endtask

    task automatic pop_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge rclk);
            rd_en = 1;
        end
        @(negedge rclk);
        rd_en = 0;
    endtask

    task automatic level(input int cnt, input string req);
        repeat (8) @(posedge wclk);
        repeat (8) @(posedge rclk);
        @(negedge wclk);
        chk(q.size() == cnt, req, "stored count", q.size(), cnt);
        chk(full == (cnt == DEPTH), "R2", "full", full, (cnt == DEPTH));
        chk(almost_full == ((DEPTH - cnt) <= exp_of), "R5", "almost_full",
            almost_full, ((DEPTH - cnt) <= exp_of));
        @(negedge rclk);
        chk(empty == (cnt == 0), "R3", "empty", empty, (cnt == 0));
        chk(almost_empty == (cnt <= exp_oe), "R4", "almost_empty",
            almost_empty, (cnt <= exp_oe));
    endtask

    task automatic ser_send(input logic [AW-1:0] v);
        for (int i = 0; i < AW; i++) begin
            @(negedge wclk);
            wr_en = 1; ser_bit = v[i]; wr_data = '1;
        end
    endtask

    initial begin
        #(200000 * 5.0);
        chk(1'b0, "R1", "watchdog expired", 0, 0);
        finish_run();
    end

    initial begin
        // R6: default offset 8, reset state
        full_reset(0); model_on = 1; exp_oe = 8; exp_of = 8;
        @(negedge wclk);
        chk(empty && !full && almost_empty && !almost_full, "R6", "reset flags",
            {empty, full, almost_empty, almost_full}, 4'b1010);
        level(0, "R6");
        push_n(8);   level(8, "R4");
        push_n(1);   level(9, "R4");
        push_n(239); level(248, "R5");
        push_n(7);   level(255, "R5");
        push_n(5);   level(256, "R2");   // four rejected while full
        pop_n(256);  level(0, "R1");
        pop_n(3);    level(0, "R3");     // reads while empty
        push_n(2); pop_n(2); level(0, "R3");

        // R6: default offsets 16 and 64
        full_reset(1); model_on = 1; exp_oe = 16; exp_of = 16;
        push_n(16); level(16, "R6");
        push_n(1);  level(17, "R6");
        full_reset(2); model_on = 1; exp_oe = 64; exp_of = 64;
        push_n(64);  level(64, "R6");
        push_n(1);   level(65, "R6");
        push_n(127); level(192, "R6");

        // R7: parallel loading
        full_reset(3);
        @(negedge wclk); wr_en = 1; wr_data = 36'd20;
        @(negedge wclk); wr_en = 1; wr_data = 36'd30;
        @(negedge wclk); wr_en = 0;
        model_on = 1; exp_oe = 20; exp_of = 30;
        level(0, "R7");
        push_n(20);  level(20, "R7");
        push_n(1);   level(21, "R7");
        push_n(205); level(226, "R7");

        // R9: partial reset keeps offsets, clears contents
        part_reset();
        level(0, "R9");
        push_n(20); level(20, "R9");
        push_n(1);  level(21, "R9");
        pop_n(21);  level(0, "R9");

        // R8: serial loading, empty offset 5, full offset 100
        full_reset(4);
        ser_send(8'd5);
        ser_send(8'd100);
        @(negedge wclk); wr_en = 0;
        model_on = 1; exp_oe = 5; exp_of = 100;
        level(0, "R8");
        push_n(5);   level(5, "R8");
        push_n(1);   level(6, "R8");
        push_n(150); level(156, "R8");
        part_reset();
        level(0, "R9");
        push_n(5);   level(5, "R9");
        push_n(151); level(156, "R9");

        // R10: unrelated clocks
        full_reset(0); model_on = 1; exp_oe = 8; exp_of = 8;
        rhalf = 3.5;
        fork
            begin
                for (int i = 0; i < 900; i++) begin
                    @(negedge wclk);
                    wctr++;
                    wr_en = (i % 3 != 0);
                    wr_data = {4'h6, 32'(wctr) * 32'h0101_0F3B};
                end
                @(negedge wclk); wr_en = 0;
            end
            begin
                for (int i = 0; i < 650; i++) begin
                    @(negedge rclk);
                    rd_en = (i % 5 != 1);
                end
                @(negedge rclk); rd_en = 0;
            end
        join
        level(q.size(), "R10");
        pop_n(400);
        level(0, "R10");
        finish_run();
    end

endmodule